// File: doc/BRIEF.md
# Far-End Fault Signalling Unit

This block carries in-band far-end fault signalling on a serial fibre-mode 100 Mb/s bit stream, one bit per clock. Its receive side watches the incoming bits for the fault pattern, which is a run of exactly 84 ones closed by a single zero. After three such patterns arrive back to back, it latches a remote-fault status bit. A set bit tells software that the local transmit path is broken, because the far end is reporting that its own receive path gets nothing usable.

Its transmit side sends the same pattern, over and over, in place of normal transmit data whenever the local receiver reports no link. This makes the far end raise its own fault indication. When link returns, the pattern in progress is completed before normal data takes over again.

Both halves work only while fibre mode is enabled. With fibre mode off, the status bit is held at 0 and transmit data passes straight through.

Top module: `farend_fault_sig`

## Requirements
- R1: A detection is scored only when a valid 0 bit follows exactly ONES_LEN (84) consecutive valid 1 bits. Runs of 83 or fewer ones, or of 85 or more, score nothing. The run counter saturates at ONES_LEN+1.
- R2: `remote_fault` rises in the cycle after the valid 0 that completes the third back-to-back detection. Any valid 0 that does not complete a pattern resets the detection count to 0. The count restarts from 0 after a fault is flagged.
- R3: Receive bits with `rx_valid` low are ignored, even a 0, and the run and detection counts hold.
- R4: `remote_fault` stays high until a cycle with `status_rd` high, and it reads 0 in the following cycle. If a new set occurs in the same cycle as the read, the set wins and the bit stays 1.
- R5: With fibre mode on and `link_ok` low, pattern output starts at count 0 in the next cycle. `tx_out` is 1 for counts 0..83 and 0 at count 84, then the count wraps and the pattern repeats.
- R6: When `link_ok` returns during pattern output, the current 85-bit pattern is completed. `tx_out` follows `tx_in` from the cycle after the closing 0.
- R7: While `fiber_en` is low, `tx_out` equals `tx_in` in the same cycle, `remote_fault` reads 0 from the next cycle, and all counters are cleared.
- R8: A synchronous active-high `rst` clears all counters and the status bit. After reset, `remote_fault` is 0 and `tx_out` follows `tx_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| fiber_en | input | 1 | Fibre mode enable; gates both detection and generation |
| rx_bit | input | 1 | Received serial bit |
| rx_valid | input | 1 | Qualifies `rx_bit` |
| link_ok | input | 1 | Local receiver reports link |
| tx_in | input | 1 | Normal transmit bit |
| status_rd | input | 1 | Status read strobe; clears the fault bit |
| tx_out | output | 1 | Transmit bit to the line |
| remote_fault | output | 1 | Latched far-end fault status |

## Verification
The bound checker tests the following on every cycle:
- the fault bit holds and clears around reads, and only rises after a valid received zero;
- fibre-off behaviour;
- the generator starts at count 0 on link loss, emits a zero at the pattern's last count, and completes a pattern once started;
- transmit pass-through while idle.

Exact run-length acceptance (83, 84, 85 and 100 ones), the need for three consecutive patterns, gaps of invalid bits inside a run, and set-over-read priority depend on long bit histories. Only the bench's scenarios and its vector table show these.

// File: rtl/farend_fault_pkg.sv
package farend_fault_pkg;

    localparam int unsigned FLT_ONES_LEN = 84;
    localparam int unsigned FLT_HITS_REQ = 3;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_SEND = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic hit;
        logic miss;
    } zero_event_t;

    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/fault_run_detect.sv
module fault_run_detect
    import farend_fault_pkg::*;
#(
    parameter int unsigned ONES_LEN = FLT_ONES_LEN,
    parameter int unsigned HITS_REQ = FLT_HITS_REQ
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_valid,
    input  logic bit_in,
    output logic fault_set
);
    localparam int unsigned RUN_MAX = ONES_LEN + 1;
    localparam int unsigned RW      = cnt_bits(RUN_MAX);
    localparam int unsigned HW      = cnt_bits(HITS_REQ);

    logic [RW-1:0] run_q;
    logic [HW-1:0] hits_q;
    zero_event_t   ev;

    always_comb begin
        ev.hit    = enable && bit_valid && !bit_in && (run_q == RW'(ONES_LEN));
        ev.miss   = enable && bit_valid && !bit_in && (run_q != RW'(ONES_LEN));
        fault_set = ev.hit && (hits_q == HW'(HITS_REQ - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q  <= '0;
            hits_q <= '0;
        end else if (bit_valid) begin
            if (bit_in) begin
                if (run_q != RW'(RUN_MAX))
                    run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
            if (ev.hit)
                hits_q <= fault_set ? '0 : hits_q + 1'b1;
            else if (ev.miss)
                hits_q <= '0;
        end
    end

endmodule

// File: rtl/fault_flag.sv
module fault_flag (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set_in,
    input  logic rd_clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst || !enable)
            flag_q <= 1'b0;
        else if (set_in)
            flag_q <= 1'b1;
        else if (rd_clr)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/fault_pattern_gen.sv
module fault_pattern_gen
    import farend_fault_pkg::*;
#(
    parameter int unsigned ONES_LEN = FLT_ONES_LEN,
    localparam int unsigned CW      = cnt_bits(ONES_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          link_ok,
    input  logic          data_in,
    output logic          data_out,
    output logic          sending,
    output logic [CW-1:0] pos
);
    gen_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == CW'(ONES_LEN));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q <= GEN_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                GEN_IDLE: begin
                    cnt_q <= '0;
                    if (!link_ok)
                        state_q <= GEN_SEND;
                end
                GEN_SEND: begin
                    if (at_last) begin
                        cnt_q <= '0;
                        if (link_ok)
                            state_q <= GEN_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= GEN_IDLE;
            endcase
        end
    end

    assign sending  = enable && (state_q == GEN_SEND);
    assign pos      = cnt_q;
    assign data_out = sending ? !at_last : data_in;

endmodule

// File: rtl/farend_fault_sig.sv
module farend_fault_sig
    import farend_fault_pkg::*;
#(
    parameter int unsigned ONES_LEN = FLT_ONES_LEN,
    parameter int unsigned HITS_REQ = FLT_HITS_REQ
) (
    input  logic clk,
    input  logic rst,
    input  logic fiber_en,
    input  logic rx_bit,
    input  logic rx_valid,
    input  logic link_ok,
    input  logic tx_in,
    input  logic status_rd,
    output logic tx_out,
    output logic remote_fault
);
    localparam int unsigned CW = cnt_bits(ONES_LEN);

    logic          fault_set;
    logic          gen_on;
    logic [CW-1:0] gen_cnt;

    fault_run_detect #(.ONES_LEN(ONES_LEN), .HITS_REQ(HITS_REQ)) u_det (
        .clk       (clk),
        .rst       (rst),
        .enable    (fiber_en),
        .bit_valid (rx_valid),
        .bit_in    (rx_bit),
        .fault_set (fault_set)
    );

    fault_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .enable (fiber_en),
        .set_in (fault_set),
        .rd_clr (status_rd),
        .flag_q (remote_fault)
    );

    fault_pattern_gen #(.ONES_LEN(ONES_LEN)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .enable   (fiber_en),
        .link_ok  (link_ok),
        .data_in  (tx_in),
        .data_out (tx_out),
        .sending  (gen_on),
        .pos      (gen_cnt)
    );

endmodule

// File: rtl/farend_fault_chk.sv
module farend_fault_chk
    import farend_fault_pkg::*;
#(
    parameter int unsigned ONES_LEN = FLT_ONES_LEN,
    localparam int unsigned CW      = cnt_bits(ONES_LEN)
) (
    input logic          clk,
    input logic          rst,
    input logic          fiber_en,
    input logic          rx_bit,
    input logic          rx_valid,
    input logic          link_ok,
    input logic          tx_in,
    input logic          status_rd,
    input logic          tx_out,
    input logic          remote_fault,
    input logic          gen_on,
    input logic [CW-1:0] gen_cnt
);
    AST_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(remote_fault) |-> $past(fiber_en && rx_valid && !rx_bit)); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        remote_fault && fiber_en && !status_rd |=> remote_fault); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        remote_fault && status_rd && !(rx_valid && !rx_bit) |=> !remote_fault); // R4
    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !fiber_en |=> !remote_fault); // R7
    AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
        !fiber_en |-> tx_out == tx_in); // R7
    AST_GEN_START: assert property (@(posedge clk) disable iff (rst)
        fiber_en && !link_ok && !gen_on |=> gen_on && gen_cnt == '0); // R5
    AST_GEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        gen_on && gen_cnt == CW'(ONES_LEN) |-> !tx_out); // R5
    AST_FINISH_PATTERN: assert property (@(posedge clk) disable iff (rst)
        fiber_en && gen_on && gen_cnt != CW'(ONES_LEN) |=> gen_on); // R6
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        !gen_on |-> tx_out == tx_in); // R6
endmodule

bind farend_fault_sig farend_fault_chk #(.ONES_LEN(ONES_LEN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fiber_en     (fiber_en),
    .rx_bit       (rx_bit),
    .rx_valid     (rx_valid),
    .link_ok      (link_ok),
    .tx_in        (tx_in),
    .status_rd    (status_rd),
    .tx_out       (tx_out),
    .remote_fault (remote_fault),
    .gen_on       (gen_on),
    .gen_cnt      (gen_cnt)
);

// File: tb/farend_fault_sig_test.sv
module farend_fault_sig_test;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst, fiber_en, rx_bit, rx_valid, link_ok, tx_in, status_rd;
    logic tx_out, remote_fault;
    int   n_checks = 0;
    int   n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    farend_fault_sig uut (
        .clk(clk), .rst(rst), .fiber_en(fiber_en), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .link_ok(link_ok), .tx_in(tx_in),
        .status_rd(status_rd), .tx_out(tx_out), .remote_fault(remote_fault)
    );

    typedef struct packed {
        logic [7:0] ones;
        logic       rd_first;
        logic       exp_flag;
    } vec_t;

    // Runs of ones each closed by a zero; R1 R2 R4 outcomes from reset state
    localparam vec_t VECS [18] = '{
        '{8'd84, 1'b0, 1'b0}, '{8'd84, 1'b0, 1'b0}, '{8'd84, 1'b0, 1'b1},
        '{8'd5,  1'b0, 1'b1}, '{8'd3,  1'b1, 1'b0}, '{8'd85, 1'b0, 1'b0},
        '{8'd84, 1'b0, 1'b0}, '{8'd84, 1'b0, 1'b0}, '{8'd100,1'b0, 1'b0},
        '{8'd84, 1'b0, 1'b0}, '{8'd84, 1'b0, 1'b0}, '{8'd84, 1'b0, 1'b1},
        '{8'd84, 1'b1, 1'b0}, '{8'd83, 1'b0, 1'b0}, '{8'd84, 1'b0, 1'b0},
        '{8'd84, 1'b0, 1'b0}, '{8'd84, 1'b0, 1'b1}, '{8'd0,  1'b1, 1'b0}
    };

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic send_run(input int n, input logic rd_on_zero, input logic gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 10 == 3)) begin
                @(negedge clk);
                rx_valid = 1'b0;
                rx_bit   = 1'b0;
            end
            @(negedge clk);
            rx_valid = 1'b1;
            rx_bit   = 1'b1;
        end
        @(negedge clk);
        rx_valid  = 1'b1;
        rx_bit    = 1'b0;
        status_rd = rd_on_zero;
        @(negedge clk);
        rx_valid  = 1'b0;
        status_rd = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; fiber_en = 1'b1; rx_bit = 1'b0; rx_valid = 1'b0;
        link_ok = 1'b1; tx_in = 1'b0; status_rd = 1'b0;
        repeat (3) @(negedge clk);
        check(remote_fault, 1'b0, "R8 reset flag");
        tx_in = 1'b1; #1;
        check(tx_out, 1'b1, "R8 reset pass-through");
        tx_in = 1'b0;
        rst = 1'b0;

        // vector table walk: R1 R2 R4
        foreach (VECS[v]) begin
            if (VECS[v].rd_first) pulse_read();
            send_run(int'(VECS[v].ones), 1'b0, 1'b0);
            check(remote_fault, VECS[v].exp_flag, $sformatf("R1 R2 R4 vector %0d", v));
        end

        // R3: invalid cycles carrying zero inside runs are ignored
        pulse_read();
        send_run(84, 1'b0, 1'b1);
        send_run(84, 1'b0, 1'b1);
        check(remote_fault, 1'b0, "R3 two gapped patterns");
        send_run(84, 1'b0, 1'b1);
        check(remote_fault, 1'b1, "R3 third gapped pattern sets");

        // R4: set wins over read in the same cycle
        pulse_read();
        check(remote_fault, 1'b0, "R4 read clears");
        send_run(84, 1'b0, 1'b0);
        send_run(84, 1'b0, 1'b0);
        send_run(84, 1'b1, 1'b0);
        check(remote_fault, 1'b1, "R4 set beats read");

        // R7: fibre mode off
        @(negedge clk); fiber_en = 1'b0;
        @(negedge clk);
        check(remote_fault, 1'b0, "R7 flag cleared when off");
        for (int k = 0; k < 3; k++) send_run(84, 1'b0, 1'b0);
        check(remote_fault, 1'b0, "R7 no detection when off");
        link_ok = 1'b0; tx_in = 1'b0;
        @(negedge clk);
        check(tx_out, 1'b0, "R7 pass-through 0 with link down");
        tx_in = 1'b1; #1;
        check(tx_out, 1'b1, "R7 pass-through 1 with link down");

        // R7: counters cleared while off, so two patterns after re-enable do not set
        fiber_en = 1'b1; link_ok = 1'b1; tx_in = 1'b0;
        send_run(84, 1'b0, 1'b0);
        send_run(84, 1'b0, 1'b0);
        check(remote_fault, 1'b0, "R7 counts restart after enable");

        // R5: generator from link loss
        send_run(0, 1'b0, 1'b0);
        @(negedge clk); link_ok = 1'b0; tx_in = 1'b0;
        for (int k = 0; k < 85; k++) begin
            @(negedge clk);
            check(tx_out, (k != 84), $sformatf("R5 pattern bit %0d", k));
        end
        // R6: link returns mid-pattern, pattern completes
        tx_in = 1'b1;
        for (int k = 0; k < 85; k++) begin
            @(negedge clk);
            if (k == 40) link_ok = 1'b1;
            check(tx_out, (k != 84), $sformatf("R6 finishing bit %0d", k));
        end
        @(negedge clk);
        check(tx_out, 1'b1, "R6 handback tx_in=1");
        tx_in = 1'b0; #1;
        check(tx_out, 1'b0, "R6 handback tx_in=0");

        // R5: restart begins at count 0
        link_ok = 1'b0;
        @(negedge clk);
        check(tx_out, 1'b1, "R5 restart first bit");

        // R8: reset in mid-pattern
        rst = 1'b1;
        @(negedge clk);
        check(tx_out, 1'b0, "R8 reset stops pattern");
        rst = 1'b0; link_ok = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule